// File: doc/BRIEF.md
# SD Host Command Engine

This block is the command path of an SD/MMC host controller. Software programs it through a small register file: it writes a 32-bit command argument, then a control word that carries the command index and two response options. The engine builds a 48-bit command frame with its CRC7, shifts it out on the CMD line on the falling edge of the card clock, and releases the line. If a response was requested it then waits for the card's start bit and captures either a 48-bit short response or a 136-bit long response.

The outcome is reported through sticky status flags: command sent, response finished, response timeout and response CRC failure. Each flag stays set until software writes a one to it. A command that expects no response is complete when the sent flag rises. A command that expects a response is complete when the response-finished flag or the timeout flag rises. The block also contains the card clock divider, which is driven by an 8-bit prescaler register.

Registers sit at byte offsets 0x00 (argument), 0x04 (control), 0x08 (status), 0x0C (prescaler) and 0x10, 0x14, 0x18, 0x1C (response words 0 to 3). Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `sdcmd_host`

## Requirements
- R1: After reset, the status and prescaler registers read 0, `cmd_oe` is low and `cmd_out` is high.
- R2: A started command drives a 48-bit frame MSB first, one bit per card clock, changing on the card clock falling edge. The frame is start bit 0, bit 1, the 6-bit index, the 32-bit argument, the CRC7 of those 40 bits, and end bit 1. For example, index 0 with argument 0 gives 0x400000000095, and index 17 with argument 0 gives 0x510000000055. After the end bit, `cmd_oe` drops.
- R3: `card_clk` has a period of 2*(P+1) bus clock cycles, where P is the prescaler value.
- R4: Control word fields: index in bits 5:0, start in bit 8, wait-for-response in bit 9, long response in bit 10. Bit 6, which marks the host as sender, is stored and read back only. A command written without bit 9 sets the sent flag (status bit 11) and never sets the response-finished flag (status bit 9).
- R5: For a short response, status bit 9 is set, status bits 7:0 hold the received index (response bits 45:40), and response word 0 holds response bits 39:8. Response words 1 to 3 keep their previous values.
- R6: If the CRC7 computed over short-response bits 47:8 differs from response bits 7:1, status bit 12 is set.
- R7: When control bit 10 is set, a 136-bit response is captured. Word 0 holds bits 127:96, word 1 holds bits 95:64, word 2 holds bits 63:32 and word 3 holds bits 31:0. Status bits 7:0 hold bits 133:128. The CRC of a long response is not checked, so status bit 12 stays 0.
- R8: If the line stays high for 64 card clock rising edges after the line is released, status bit 10 is set, the engine returns to idle and status bit 9 stays 0.
- R9: Status bits 9 to 12 are sticky. Writing a one to a bit clears only that bit. Writing 0xFFFFFFFF clears all of them.
- R10: A control write made while a command is in progress is ignored. It does not start a second frame and it does not change the stored control word.
- R11: Status bit 8 reads 1 from the cycle after the start write until the command finishes.
- R12: The argument and prescaler registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| card_clk | output | 1 | Divided card clock |
| cmd_out | output | 1 | CMD line value driven by the host |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line value seen from the card |

## Verification
The bench uses the default parameters: an 8-bit address, an 8-bit prescaler and a 64-clock response timeout. With these, the timeout boundary is checked exactly, one card clock before it and on it. At run time it programs prescaler values 0, 1 and 2, which exercises both the edge case with no divide and real divided periods. Most traffic runs at prescaler 1, so a 136-bit response fits in a few hundred bus cycles. A behavioural card model decodes the frame from the pins and answers with short, long and corrupted-CRC responses, or stays silent.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   // register byte offsets
   localparam int unsigned OFF_ARG   = 'h00;
   localparam int unsigned OFF_CTRL  = 'h04;
   localparam int unsigned OFF_STAT  = 'h08;
   localparam int unsigned OFF_PRE   = 'h0C;
   localparam int unsigned OFF_RSP0  = 'h10;

   // control word bit positions
   localparam int unsigned CB_START = 8;
   localparam int unsigned CB_WAIT  = 9;
   localparam int unsigned CB_LONG  = 10;

   // status word bit positions
   localparam int unsigned SB_BUSY = 8;
   localparam int unsigned SB_RFIN = 9;
   localparam int unsigned SB_TOUT = 10;
   localparam int unsigned SB_SENT = 11;
   localparam int unsigned SB_CRC  = 12;

   localparam int unsigned FRAME_LEN = 48;
   localparam int unsigned SHORT_LEN = 48;
   localparam int unsigned LONG_LEN  = 136;
   localparam int unsigned BCNT_W    = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TX,
      ST_WAIT,
      ST_RX,
      ST_FIN
   } eng_state_t;

   // CRC7, polynomial x^7 + x^3 + 1, over a 40-bit header, MSB first
   function automatic logic [6:0] crc7_calc(input logic [39:0] d);
      logic [6:0] c;
      logic       fb;
      c = '0;
      for (int i = 39; i >= 0; i--) begin
         fb = d[i] ^ c[6];
         c  = {c[5:3], c[2] ^ fb, c[1:0], fb};
      end
      return c;
   endfunction

endpackage

// File: rtl/sdcmd_clkdiv.sv
module sdcmd_clkdiv #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] pre,
   output logic             card_clk,
   output logic             rise_tick,
   output logic             fall_tick
);

   logic [PRE_W-1:0] cnt;
   logic             wrap;

   // ">=" keeps the divider sane when the prescaler is lowered mid-count
   assign wrap      = (cnt >= pre);
   assign rise_tick = wrap & ~card_clk;
   assign fall_tick = wrap &  card_clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         card_clk <= 1'b0;
      end else if (wrap) begin
         cnt      <= '0;
         card_clk <= ~card_clk;
      end else begin
         cnt      <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
   import sdcmd_pkg::*;
#(
   parameter int TOUT_CLKS = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rise_tick,
   input  logic        fall_tick,
   input  logic        start,
   input  logic [5:0]  idx,
   input  logic [31:0] arg,
   input  logic        want_rsp,
   input  logic        long_rsp,
   input  logic        cmd_in,
   output logic        cmd_out,
   output logic        cmd_oe,
   output logic        busy,
   output logic        ev_sent,
   output logic        ev_rspfin,
   output logic        ev_tout,
   output logic        ev_crcerr,
   output logic        rsp_long,
   output logic [7:0]  rsp_idx,
   output logic [31:0] rsp_word [4]
);

   localparam int TW = (TOUT_CLKS > 2) ? $clog2(TOUT_CLKS) : 1;

   eng_state_t              st;
   logic [FRAME_LEN-1:0]    tx_sr;
   logic [LONG_LEN-3:0]     rx_sr;
   logic [BCNT_W-1:0]       bcnt;
   logic [TW-1:0]           tcnt;
   logic                    lng;
   logic                    want;
   logic [39:0]             head;
   logic [BCNT_W-1:0]       rx_last;
   logic                    crc_ok;

   assign head     = {2'b01, idx, arg};
   assign rx_last  = lng ? BCNT_W'(LONG_LEN - 1) : BCNT_W'(SHORT_LEN - 1);
   assign crc_ok   = (crc7_calc(rx_sr[47:8]) == rx_sr[7:1]);
   assign busy     = (st != ST_IDLE);
   assign rsp_long = lng;
   assign rsp_idx  = lng ? {2'b00, rx_sr[133:128]} : {2'b00, rx_sr[45:40]};

   for (genvar k = 0; k < 4; k++) begin : g_word
      if (k == 0) begin : g_first
         assign rsp_word[k] = lng ? rx_sr[127:96] : rx_sr[39:8];
      end else begin : g_rest
         assign rsp_word[k] = rx_sr[127-32*k -: 32];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tx_sr     <= '0;
         rx_sr     <= '0;
         bcnt      <= '0;
         tcnt      <= '0;
         lng       <= 1'b0;
         want      <= 1'b0;
         cmd_out   <= 1'b1;
         cmd_oe    <= 1'b0;
         ev_sent   <= 1'b0;
         ev_rspfin <= 1'b0;
         ev_tout   <= 1'b0;
         ev_crcerr <= 1'b0;
      end else begin
         ev_sent   <= 1'b0;
         ev_rspfin <= 1'b0;
         ev_tout   <= 1'b0;
         ev_crcerr <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  tx_sr <= {head, crc7_calc(head), 1'b1};
                  bcnt  <= '0;
                  lng   <= long_rsp;
                  want  <= want_rsp;
                  st    <= ST_TX;
               end
            end
            ST_TX: begin
               if (fall_tick) begin
                  if (bcnt == BCNT_W'(FRAME_LEN)) begin
                     cmd_oe  <= 1'b0;
                     cmd_out <= 1'b1;
                     ev_sent <= 1'b1;
                     tcnt    <= '0;
                     st      <= want ? ST_WAIT : ST_IDLE;
                  end else begin
                     cmd_oe  <= 1'b1;
                     cmd_out <= tx_sr[FRAME_LEN-1];
                     tx_sr   <= {tx_sr[FRAME_LEN-2:0], 1'b0};
                     bcnt    <= bcnt + 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (rise_tick) begin
                  if (!cmd_in) begin
                     rx_sr <= {rx_sr[LONG_LEN-4:0], 1'b0};
                     bcnt  <= BCNT_W'(1);
                     st    <= ST_RX;
                  end else if (tcnt == TW'(TOUT_CLKS - 1)) begin
                     ev_tout <= 1'b1;
                     st      <= ST_IDLE;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_RX: begin
               if (rise_tick) begin
                  rx_sr <= {rx_sr[LONG_LEN-4:0], cmd_in};
                  bcnt  <= bcnt + 1'b1;
                  if (bcnt == rx_last) st <= ST_FIN;
               end
            end
            ST_FIN: begin
               ev_rspfin <= 1'b1;
               ev_crcerr <= !lng && !crc_ok;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
   import sdcmd_pkg::*;
#(
   parameter int AW        = 8,
   parameter int PRE_W     = 8,
   parameter int TOUT_CLKS = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          card_clk,
   output logic          cmd_out,
   output logic          cmd_oe,
   input  logic          cmd_in
);

   if (AW < 5 || AW > 32) begin : g_bad_aw
      $error("sdcmd_host: AW must lie in 5..32");
   end
   if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre
      $error("sdcmd_host: PRE_W must lie in 1..16");
   end
   if (TOUT_CLKS < 2) begin : g_bad_tout
      $error("sdcmd_host: TOUT_CLKS must be at least 2");
   end

   logic [31:0]      arg_q;
   logic [10:0]      ctrl_q;
   logic [PRE_W-1:0] pre_q;
   logic             st_rf, st_to, st_sent, st_crc;
   logic [7:0]       rsp_idx_q;
   logic [31:0]      rsp_q [4];

   logic rise_tick, fall_tick;
   logic eng_busy, ev_sent, ev_rspfin, ev_tout, ev_crcerr, rsp_long;
   logic [7:0]  eng_idx;
   logic [31:0] eng_word [4];
   logic sel_arg, sel_ctrl, sel_stat, sel_pre, wr_stat, start;

   assign sel_arg  = (reg_addr == AW'(OFF_ARG));
   assign sel_ctrl = (reg_addr == AW'(OFF_CTRL));
   assign sel_stat = (reg_addr == AW'(OFF_STAT));
   assign sel_pre  = (reg_addr == AW'(OFF_PRE));
   assign wr_stat  = reg_wr && sel_stat;
   assign start    = reg_wr && sel_ctrl && reg_wdata[CB_START] && !eng_busy;

   sdcmd_clkdiv #(.PRE_W(PRE_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre       (pre_q),
      .card_clk  (card_clk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   sdcmd_engine #(.TOUT_CLKS(TOUT_CLKS)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .start     (start),
      .idx       (reg_wdata[5:0]),
      .arg       (arg_q),
      .want_rsp  (reg_wdata[CB_WAIT]),
      .long_rsp  (reg_wdata[CB_LONG]),
      .cmd_in    (cmd_in),
      .cmd_out   (cmd_out),
      .cmd_oe    (cmd_oe),
      .busy      (eng_busy),
      .ev_sent   (ev_sent),
      .ev_rspfin (ev_rspfin),
      .ev_tout   (ev_tout),
      .ev_crcerr (ev_crcerr),
      .rsp_long  (rsp_long),
      .rsp_idx   (eng_idx),
      .rsp_word  (eng_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arg_q     <= '0;
         ctrl_q    <= '0;
         pre_q     <= '0;
         st_rf     <= 1'b0;
         st_to     <= 1'b0;
         st_sent   <= 1'b0;
         st_crc    <= 1'b0;
         rsp_idx_q <= '0;
      end else begin
         if (reg_wr && sel_arg) arg_q <= reg_wdata;
         if (reg_wr && sel_pre) pre_q <= reg_wdata[PRE_W-1:0];
         if (start)             ctrl_q <= reg_wdata[10:0];
         // a new event wins over a simultaneous clear
         st_rf   <= ev_rspfin | (st_rf   & ~(wr_stat & reg_wdata[SB_RFIN]));
         st_to   <= ev_tout   | (st_to   & ~(wr_stat & reg_wdata[SB_TOUT]));
         st_sent <= ev_sent   | (st_sent & ~(wr_stat & reg_wdata[SB_SENT]));
         st_crc  <= ev_crcerr | (st_crc  & ~(wr_stat & reg_wdata[SB_CRC]));
         if (ev_rspfin) rsp_idx_q <= eng_idx;
      end
   end

   for (genvar k = 0; k < 4; k++) begin : g_rsp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rsp_q[k] <= '0;
         else if (ev_rspfin && (k == 0 || rsp_long))
            rsp_q[k] <= eng_word[k];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(OFF_ARG):      reg_rdata = arg_q;
         AW'(OFF_CTRL):     reg_rdata = {21'b0, ctrl_q};
         AW'(OFF_STAT):     reg_rdata = {19'b0, st_crc, st_sent, st_to, st_rf, eng_busy, rsp_idx_q};
         AW'(OFF_PRE):      reg_rdata = 32'(pre_q);
         AW'(OFF_RSP0):     reg_rdata = rsp_q[0];
         AW'(OFF_RSP0 + 4): reg_rdata = rsp_q[1];
         AW'(OFF_RSP0 + 8): reg_rdata = rsp_q[2];
         AW'(OFF_RSP0 + 12): reg_rdata = rsp_q[3];
         default:           reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sdcmd_host_chk.sv
module sdcmd_host_chk
   import sdcmd_pkg::*;
#(
   parameter int AW    = 8,
   parameter int PRE_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [AW-1:0]    reg_addr,
   input logic [31:0]      reg_wdata,
   input logic             card_clk,
   input logic             cmd_out,
   input logic             cmd_oe,
   input logic             busy,
   input logic             st_rf,
   input logic             st_to,
   input logic [PRE_W-1:0] pre
);

   logic clr_to, clr_rf;
   assign clr_to = reg_wr && (reg_addr == AW'(OFF_STAT)) && reg_wdata[SB_TOUT];
   assign clr_rf = reg_wr && (reg_addr == AW'(OFF_STAT)) && reg_wdata[SB_RFIN];

   // R10: the line is driven only while a command is in flight
   p_drive_in_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> busy);

   // R10: a command only begins after a start write
   p_start_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && (reg_addr == AW'(OFF_CTRL)) && reg_wdata[CB_START]));

   // R2: the last driven bit before release is the end bit
   p_end_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> $past(cmd_out));

   // R3: with a nonzero prescaler the card clock holds for more than one cycle
   p_clk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (($rose(card_clk) || $fell(card_clk)) && pre != '0) |=> $stable(card_clk));

   // R9: the timeout flag stays set until cleared
   p_tout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_to && !clr_to) |=> st_to);

   // R9: the response-finished flag stays set until cleared
   p_rfin_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rf && !clr_rf) |=> st_rf);

   // R8: timeout and response finish never arise together
   p_tout_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_to) |-> !$rose(st_rf));

endmodule

bind sdcmd_host sdcmd_host_chk #(.AW(AW), .PRE_W(PRE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .card_clk  (card_clk),
   .cmd_out   (cmd_out),
   .cmd_oe    (cmd_oe),
   .busy      (eng_busy),
   .st_rf     (st_rf),
   .st_to     (st_to),
   .pre       (pre_q)
);

// File: tb/sim_sdcmd_host.sv
`timescale 1ns/1ps
module sim_sdcmd_host;

   localparam int AW = 8;
   localparam logic [7:0] A_ARG = 8'h00, A_CTRL = 8'h04, A_STAT = 8'h08, A_PRE = 8'h0C,
                          A_R0 = 8'h10, A_R1 = 8'h14, A_R2 = 8'h18, A_R3 = 8'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          card_clk, cmd_out, cmd_oe;
   logic          cmd_in = 1'b1;

   int checks = 0;
   int errors = 0;
   int oe_rises = 0;

   always #10 clk = ~clk;

   sdcmd_host u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_clk(card_clk),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
   );

   always @(posedge cmd_oe) oe_rises++;

   task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [6:0] ref_crc(input logic [39:0] v);
      logic [6:0] r;
      logic       t;
      r = '0;
      for (int i = 39; i >= 0; i--) begin
         t = r[6];
         r = r << 1;
         if (t ^ v[i]) r = r ^ 7'h09;
      end
      return r;
   endfunction

   task automatic grab_frame(output logic [47:0] f);
      f = '0;
      @(posedge cmd_oe);
      for (int i = 0; i < 48; i++) begin
         @(posedge card_clk);
         #1 f = {f[46:0], cmd_out};
      end
      @(negedge cmd_oe);
      #1;
   endtask

   task automatic send_rsp(input logic [135:0] bits, input int n, input int gap);
      for (int g = 0; g < gap; g++) @(negedge card_clk);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge card_clk);
         #1 cmd_in = bits[i];
      end
      @(negedge card_clk);
      #1 cmd_in = 1'b1;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(A_STAT, s);
         if (!s[8]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_STAT, d); chk("R1 status after reset", d, 0);
      rd(A_PRE, d);  chk("R1 prescaler after reset", d, 0);
      chk("R1 cmd_oe low", cmd_oe, 0);
      chk("R1 cmd_out high", cmd_out, 1);
      wr(A_ARG, 32'hA5C3_0F1E); rd(A_ARG, d); chk("R12 argument readback", d, 32'hA5C3_0F1E);
   endtask

   task automatic t_clock(input int p);
      realtime t0, t1;
      logic [31:0] d;
      wr(A_PRE, p);
      rd(A_PRE, d); chk("R12 prescaler readback", d, p);
      repeat (3) @(posedge card_clk);
      t0 = $realtime;
      @(posedge card_clk);
      t1 = $realtime;
      chk("R3 card clock period (bus cycles)", int'((t1 - t0) / 20.0), 2 * (p + 1));
   endtask

   task automatic t_noresp();
      logic [47:0] f;
      logic [31:0] s;
      wr(A_ARG, 32'h0);
      fork
         grab_frame(f);
         begin
            wr(A_CTRL, 32'h140);
            rd(A_STAT, s); chk("R11 busy during command", s[8], 1);
         end
      join
      chk("R2 frame index 0", f, 48'h400000000095);
      chk("R2 line released", cmd_oe, 0);
      wait_idle();
      rd(A_STAT, s);
      chk("R4 sent flag set", s[11], 1);
      chk("R4 response flag clear", s[9], 0);
      chk("R11 busy cleared", s[8], 0);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, s); chk("R9 all-ones clear", s[12:9], 0);
   endtask

   task automatic t_long();
      logic [47:0]  f;
      logic [31:0]  d;
      logic [135:0] r;
      r = {2'b00, 6'h3F, 128'h01234567_89ABCDEF_FEDCBA98_76543211};
      wr(A_ARG, 32'h0001_0000);
      fork
         grab_frame(f);
         wr(A_CTRL, 32'h742);
      join
      chk("R2 frame header long cmd", f[47:8], {2'b01, 6'd2, 32'h0001_0000});
      chk("R2 frame crc long cmd", f[7:1], ref_crc(f[47:8]));
      send_rsp(r, 136, 2);
      wait_idle();
      rd(A_STAT, d);
      chk("R7 response finished", d[9], 1);
      chk("R7 index field", d[7:0], 8'h3F);
      chk("R7 no crc check", d[12], 0);
      rd(A_R0, d); chk("R7 word0", d, 32'h01234567);
      rd(A_R1, d); chk("R7 word1", d, 32'h89ABCDEF);
      rd(A_R2, d); chk("R7 word2", d, 32'hFEDCBA98);
      rd(A_R3, d); chk("R7 word3", d, 32'h76543211);
      wr(A_STAT, 32'hFFFF_FFFF);
   endtask

   task automatic t_short(input bit corrupt);
      logic [47:0]  f;
      logic [31:0]  d;
      logic [39:0]  h;
      logic [6:0]   c;
      h = {2'b00, 6'd17, 32'h0000_0900};
      c = ref_crc(h) ^ {6'b0, corrupt};
      wr(A_ARG, 32'h0);
      fork
         grab_frame(f);
         wr(A_CTRL, 32'h351);
      join
      if (!corrupt) chk("R2 frame index 17", f, 48'h510000000055);
      send_rsp({88'b0, h, c, 1'b1}, 48, 1);
      wait_idle();
      rd(A_STAT, d);
      if (corrupt) begin
         chk("R6 crc failure flagged", d[12], 1);
         chk("R6 response still finished", d[9], 1);
      end else begin
         chk("R5 response finished", d[9], 1);
         chk("R5 received index", d[7:0], 8'd17);
         chk("R5 no crc failure", d[12], 0);
         chk("R4 sent flag with response", d[11], 1);
         rd(A_R0, d); chk("R5 word0 card status", d, 32'h0000_0900);
         rd(A_R1, d); chk("R5 word1 untouched", d, 32'h89ABCDEF);
         wr(A_STAT, 32'h200);
         rd(A_STAT, d);
         chk("R9 single clear of bit 9", d[9], 0);
         chk("R9 bit 11 kept", d[11], 1);
      end
      wr(A_STAT, 32'hFFFF_FFFF);
   endtask

   task automatic t_timeout();
      logic [47:0] f;
      logic [31:0] d;
      wr(A_ARG, 32'h0002_0000);
      fork
         grab_frame(f);
         wr(A_CTRL, 32'h349);
      join
      repeat (63) @(posedge card_clk);
      rd(A_STAT, d);
      chk("R8 no timeout at 63 clocks", d[10], 0);
      chk("R8 still busy at 63 clocks", d[8], 1);
      @(posedge card_clk);
      repeat (2) @(negedge clk);
      rd(A_STAT, d);
      chk("R8 timeout at 64 clocks", d[10], 1);
      chk("R8 idle after timeout", d[8], 0);
      chk("R8 no response flag", d[9], 0);
      wr(A_STAT, 32'h400);
      rd(A_STAT, d); chk("R9 timeout cleared by one", d[10], 0);
      wr(A_STAT, 32'hFFFF_FFFF);
   endtask

   task automatic t_busy_start();
      logic [47:0] f;
      logic [31:0] d;
      int          base;
      base = oe_rises;
      wr(A_ARG, 32'h0);
      fork
         grab_frame(f);
         begin
            wr(A_CTRL, 32'h140);
            repeat (10) @(negedge clk);
            wr(A_CTRL, 32'h145);
         end
      join
      chk("R10 frame unchanged", f, 48'h400000000095);
      wait_idle();
      repeat (300) @(negedge clk);
      chk("R10 single frame", oe_rises - base, 1);
      rd(A_CTRL, d); chk("R10 control word kept", d, 32'h140);
      wr(A_STAT, 32'hFFFF_FFFF);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clock(0);
      t_clock(2);
      t_clock(1);
      t_noresp();
      t_long();
      t_short(1'b0);
      t_short(1'b1);
      t_timeout();
      t_busy_start();
      finish_run();
   end

endmodule